// File: doc/BRIEF.md
# Bidirectional Reset Line Controller

This block owns a single open-drain, active-low reset line of a small monitoring device. Software starts an outgoing reset by writing 1 to a control bit. The block then pulls the line low for a minimum time, counted in strobes of a slow timing tick. When that time has passed, it releases the line and clears the control bit itself. The length in ticks is the tick rate multiplied by the pulse time in milliseconds, rounded up, so the minimum width is always met.

While the block is not driving, the same line is an input. The pad level goes through a synchronizer and a two-sample low filter. A low level that someone else holds on the line then raises a request that returns the configuration registers, and the DAC data register, to their power-on values. No request is made for the other value-RAM locations. The block's own pulse is masked for as long as it drives the line and for the few cycles the synchronizer needs to show the released level, so the block never resets the device with its own pulse.

Top module: `rst_line_ctrl`

## Requirements
- R1: Writing 1 to the control bit (`cfg_we_i`=1, `cfg_wdata_i`=1) while idle makes `start_bit_o` and `pad_oe_o` read 1 in the cycle after the write edge.
- R2: With N = ceil(TICK_HZ*PULSE_MS/1000), the line is held driven for exactly N+1 tick strobes after the start edge, and the pulse ends on the last of them. The width is therefore at least N tick periods.
- R3: On the edge that ends the pulse, `start_bit_o` returns to 0 and `pad_oe_o` is released at the same time.
- R4: A write of either value to the control bit while a pulse runs has no effect: the pulse is neither restarted, nor extended, nor cut short.
- R5: Writing 0 to the control bit while idle leaves `start_bit_o` and `pad_oe_o` at 0.
- R6: A low level on `pad_i` that covers L ≥ 2 consecutive clock edges, while the line is not masked, raises `reg_rst_req_o` after the third edge following the first low edge. The request stays high for L-1 cycles.
- R7: A low on `pad_i` that covers only one clock edge produces no request.
- R8: No request is raised while the block drives the line, nor during the three cycles after it releases. An external low that lasts past the release raises the request on the fifth edge after the release.
- R9: `dac_rst_req_o` equals `reg_rst_req_o` in every cycle. There is no request for the other value-RAM locations.
- R10: After reset, `start_bit_o`, `pad_oe_o`, `reg_rst_req_o` and `dac_rst_req_o` are all 0. `pad_oe_o` = 1 means the pad pulls low. The line is never driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Single-cycle timing strobe at TICK_HZ |
| cfg_we_i | input | 1 | Write strobe for the control bit |
| cfg_wdata_i | input | 1 | Value written to the control bit |
| start_bit_o | output | 1 | Readback of the control bit (1 while a pulse runs) |
| pad_oe_o | output | 1 | Open-drain enable: 1 pulls the line low |
| pad_i | input | 1 | Asynchronous sampled level of the line |
| reg_rst_req_o | output | 1 | Request to restore configuration registers to defaults |
| dac_rst_req_o | output | 1 | Request to restore the DAC data register |

## Verification
Both the control bit and the drive enable show a write one cycle after its edge. The bench samples them 1 ns after the following falling edge, and it checks the release in the sample where the drive enable is first seen low. An external low passes three registers before the request appears, so a vector table gives, for each low length, the expected first-high sample (the fourth falling edge after the low begins) and the expected number of high cycles. The pulse width is counted in tick strobes that are consumed while the drive is active. An external low held across the release must give its first request sample exactly five cycles after the release, which follows from three masked cycles plus two filter samples.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
  localparam int unsigned MS_PER_S = 1000;

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/rlc_sync.sv
module rlc_sync #(
  parameter int unsigned STAGES   = 2,
  parameter bit          RST_VAL  = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= RST_VAL;
        else         stage_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= {STAGES{RST_VAL}};
        else         stage_q <= {stage_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rlc_pulse_timer.sv
module rlc_pulse_timer #(
  parameter int unsigned TICK_HZ  = 32768,
  parameter int unsigned PULSE_MS = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic wr_en_i,
  input  logic wr_bit_i,
  output logic busy_o
);
  localparam int unsigned PULSE_TICKS = rlc_pkg::ceil_div(TICK_HZ * PULSE_MS, rlc_pkg::MS_PER_S);
  localparam int unsigned CNT_W       = $clog2(PULSE_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(PULSE_TICKS);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             start, finish;

  // writes during a pulse are dropped
  assign start  = !busy_q && wr_en_i && wr_bit_i;
  // N+1 ticks so a tick right after start never shortens the pulse
  assign finish = busy_q && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (finish) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q && tick_i) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;

  // R1
  start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && wr_en_i && wr_bit_i) |=> busy_q);
  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  // R2
  end_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !tick_i) |=> busy_q);
  // R4
  write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && wr_en_i && !tick_i) |=> (busy_q && $stable(cnt_q)));
endmodule

// File: rtl/rlc_req_filter.sv
module rlc_req_filter #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic drive_i,
  output logic req_o
);
  // blanking covers synchronizer lag plus one filter sample after release
  localparam int unsigned GUARD   = SYNC_STAGES + 1;
  localparam int unsigned GUARD_W = $clog2(GUARD + 1);

  logic [GUARD_W-1:0] guard_q;
  logic               masked;
  logic               low_q, req_q;

  assign masked = drive_i || (guard_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              guard_q <= '0;
    else if (drive_i)         guard_q <= GUARD_W'(GUARD);
    else if (guard_q != '0)   guard_q <= guard_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q <= 1'b0;
      req_q <= 1'b0;
    end else if (masked) begin
      low_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      low_q <= !level_i;
      req_q <= !level_i && low_q;
    end
  end

  assign req_o = req_q;

  // R8
  mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    masked |=> !req_q);
  // R7
  two_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> $past(low_q));
endmodule

// File: rtl/rst_line_ctrl.sv
module rst_line_ctrl #(
  parameter int unsigned TICK_HZ     = 32768,
  parameter int unsigned PULSE_MS    = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic cfg_we_i,
  input  logic cfg_wdata_i,
  output logic start_bit_o,
  output logic pad_oe_o,
  input  logic pad_i,
  output logic reg_rst_req_o,
  output logic dac_rst_req_o
);
  logic busy;
  logic level_sync;
  logic req;

  rlc_pulse_timer #(
    .TICK_HZ  (TICK_HZ),
    .PULSE_MS (PULSE_MS)
  ) timer_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .wr_en_i  (cfg_we_i),
    .wr_bit_i (cfg_wdata_i),
    .busy_o   (busy)
  );

  rlc_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_i),
    .q_o    (level_sync)
  );

  rlc_req_filter #(
    .SYNC_STAGES (SYNC_STAGES)
  ) filter_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (level_sync),
    .drive_i (busy),
    .req_o   (req)
  );

  assign start_bit_o   = busy;
  assign pad_oe_o      = busy;
  assign reg_rst_req_o = req;
  assign dac_rst_req_o = req;

  // R8
  no_self_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_oe_o |-> !reg_rst_req_o);
  // R9
  dac_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_rst_req_o == reg_rst_req_o);
endmodule

// File: tb/rst_line_ctrl_tb_top.sv
module rst_line_ctrl_tb_top;
  localparam int unsigned TICK_HZ  = 1025;
  localparam int unsigned PULSE_MS = 20;
  localparam int N        = 21;   // ceil(1025*20/1000)
  localparam int TICK_DIV = 4;
  // {low edges, expected high cycles, expected first-high sample}
  localparam int VEC [4][3] = '{'{1, 0, 0}, '{2, 1, 4}, '{3, 2, 4}, '{5, 4, 4}};

  logic clk = 1'b0, rst_ni = 1'b0;
  logic tick = 1'b0, we = 1'b0, wd = 1'b0, ext_low = 1'b0;
  logic start_bit, oe, req, dac, pad;
  int errors = 0, checks = 0, tcnt = 0;

  assign pad = !(oe || ext_low);

  rst_line_ctrl #(.TICK_HZ(TICK_HZ), .PULSE_MS(PULSE_MS), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .cfg_we_i(we), .cfg_wdata_i(wd),
    .start_bit_o(start_bit), .pad_oe_o(oe), .pad_i(pad),
    .reg_rst_req_o(req), .dac_rst_req_o(dac));

  initial forever #4 clk = !clk;

  initial forever begin
    @(negedge clk);
    tcnt++;
    tick = (tcnt % TICK_DIV == 0);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ext_test(input int l, input int exp_cnt, input int exp_first);
    int cnt = 0, first = 0, mism = 0;
    @(negedge clk); ext_low = 1'b1;
    for (int j = 1; j <= 12; j++) begin
      @(negedge clk);
      if (j == l) ext_low = 1'b0;
      #1;
      if (req) begin cnt++; if (first == 0) first = j; end
      if (dac != req) mism++;
    end
    chk(cnt == exp_cnt, l < 2 ? "R7 glitch count" : "R6 request length", cnt, exp_cnt);
    chk(first == exp_first, "R6 request timing", first, exp_first);
    chk(mism == 0, "R9 dac follows", mism, 0);
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_test(input bit poke, input bit hold_ext);
    int cyc = 0, ticks = 0, req_seen = 0, first = 0;
    @(negedge clk); we = 1'b1; wd = 1'b1;
    @(negedge clk); we = 1'b0; #1;
    chk(oe && start_bit, "R1 start", {oe, start_bit}, 3);
    while (oe && cyc < 500) begin
      if (tick) ticks++;
      if (req) req_seen++;
      cyc++;
      @(negedge clk);
      if (poke && cyc == 10)      begin we = 1'b1; wd = 1'b1; end
      else if (poke && cyc == 20) begin we = 1'b1; wd = 1'b0; end
      else we = 1'b0;
      if (hold_ext && cyc == 30) ext_low = 1'b1;
      #1;
    end
    chk(start_bit == 1'b0, "R3 self clear", start_bit, 0);
    chk(ticks == N + 1, poke ? "R4 ticks with writes" : "R2 ticks", ticks, N + 1);
    chk(cyc >= N * TICK_DIV && cyc <= (N + 1) * TICK_DIV, "R2 width", cyc, N * TICK_DIV);
    for (int j = 1; j <= 10; j++) begin
      @(negedge clk);
      if (j == 8) ext_low = 1'b0;
      #1;
      if (req && first == 0) first = j;
      if (!hold_ext && req) req_seen++;
    end
    chk(req_seen == 0, "R8 masked", req_seen, 0);
    if (hold_ext) chk(first == 5, "R8 late request", first, 5);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk({start_bit, oe, req, dac} == 4'b0, "R10 reset state", {start_bit, oe, req, dac}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk({start_bit, oe, req, dac} == 4'b0, "R10 after release", {start_bit, oe, req, dac}, 0);
    // R5: write 0 while idle
    @(negedge clk); we = 1'b1; wd = 1'b0;
    @(negedge clk); we = 1'b0; #1;
    chk(!start_bit && !oe, "R5 idle zero write", {start_bit, oe}, 0);
    repeat (4) @(negedge clk);
    for (int v = 0; v < 4; v++) ext_test(VEC[v][0], VEC[v][1], VEC[v][2]);
    pulse_test(1'b0, 1'b0);
    pulse_test(1'b1, 1'b0);
    pulse_test(1'b0, 1'b1);
    ext_test(2, 1, 4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule